// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block is one DMA channel. It moves a run of equal-width elements between a fixed device address and an incrementing memory address. Software loads four channel words through a small write port: device address, memory address, size and link. It then picks a mode and pulses start. In single mode the engine performs the one transfer held in those words. In chain mode it treats the link word as a pointer. It reads a four-word descriptor from memory into the same four words, performs that transfer, and keeps following links until a descriptor marks the end of the chain.

Each element moves as one beat of two bus cycles: a read, then a write, on a request/grant memory port. The direction input chooses which side is the source. The size word packs a width code above the element count, and each width has its own count limit. A descriptor whose size word breaks those rules aborts the chain with an error pulse. The two low bits of the link word decide two things: whether the chain goes on, and whether a completion pulse is raised once that descriptor is done.

Top module: `lde_channel`

## Requirements
- R1: After reset the channel is idle with state 0, requests no bus access, and raises neither event.
- R2: In single mode (mode 2), a start pulse in idle moves N elements, where N is size bits 11:0. Each element is one bus read followed by one bus write, both through the request/grant port.
- R3: With dir=1 each beat reads memory and writes the device address; with dir=0 it reads the device address and writes memory. The device address never changes during a transfer.
- R4: Size bits 13:12 give the element width: code 3 is 1 byte, code 2 is 2 bytes, code 0 is 4 bytes. After each beat the memory address advances by that many bytes.
- R5: In chain mode (mode 1), start reads four words from the link address. The words are read in order from offsets 0x0, 0x4, 0x8 and 0xC, and they load device address, memory address, size and link respectively. The transfer they describe is then performed.
- R6: Link bit 1 set means follow, and bit 0 set means interrupt. When a descriptor's transfer finishes, evt_done pulses once if bit 0 is set. In chain mode, a set bit 1 makes the engine fetch the next descriptor from the link's upper bits. In single mode the follow bit has no effect.
- R7: Certain size words raise one evt_err pulse and return the channel to idle with no data beat. These are: width code 1, a count above 0x3FF with width code 3 or 2, and a count above 0x7FF with width code 0. Counts of exactly 0x3FF or 0x7FF are accepted.
- R8: chan_state reports 0 when idle, 1 while reading a descriptor, 2 while checking the size word, and 3 while moving data. No bus request is made while idle.
- R9: A start pulse while the channel is busy is ignored. So are register writes while busy.
- R10: Setting mode to 0 during a transfer stops the channel after the beat in progress completes its write. The channel returns to idle with no completion pulse.
- R11: A bus request stays asserted, with its address and write flag unchanged, until it is granted.
- R12: A descriptor with a count of 0 moves no data but still completes, pulsing evt_done if its link bit 0 is set.
- R13: Descriptor reads use the link address with its two low bits cleared, so every fetch is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 off, 1 chain, 2 single, 3 reserved (start does nothing) |
| dir | input | 1 | 1 memory to device, 0 device to memory |
| start | input | 1 | Start pulse, taken only when idle |
| reg_we | input | 1 | Channel register write strobe |
| reg_idx | input | 2 | Register index: 0 device, 1 memory, 2 size, 3 link |
| reg_wdata | input | DW | Register write data |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | DW | Byte address of the access |
| bus_wdata | output | DW | Write data |
| bus_gnt | input | 1 | Grant; the access completes in this cycle |
| bus_rdata | input | DW | Read data, valid in the grant cycle |
| chan_state | output | 2 | Channel state code |
| evt_done | output | 1 | One-cycle completion pulse |
| evt_err | output | 1 | One-cycle size-error pulse |

## Verification
Data moves are tried in both directions and with all three widths. The 2-byte and 1-byte runs expose the memory stride, which 4-byte runs alone would hide. A two-descriptor chain with a misaligned head pointer checks the fetch order, the alignment, the link following and the interrupt pulse per descriptor. Zero counts, the exact count limits, over-limit counts and the reserved width code separate acceptance from rejection. Mid-run start pulses and register writes, together with a mid-run switch to mode 0, show that busy-time stimulus is ignored and that stopping happens only on beat boundaries. The grant stream is throttled throughout so that request holding is exercised.

// File: rtl/lde_pkg.sv
package lde_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_DECODE = 2'd2,
        ST_MOVE   = 2'd3
    } lde_state_e;

    typedef enum logic [1:0] {
        MD_OFF    = 2'd0,
        MD_CHAIN  = 2'd1,
        MD_SINGLE = 2'd2,
        MD_RSVD   = 2'd3
    } lde_mode_e;

    localparam int CNT_W   = 12;
    localparam int WCODE_LSB = 12;

    localparam logic [1:0] WC_BYTE = 2'd3;
    localparam logic [1:0] WC_HALF = 2'd2;
    localparam logic [1:0] WC_WORD = 2'd0;

    localparam logic [CNT_W-1:0] LIM_NARROW = 12'h3FF;
    localparam logic [CNT_W-1:0] LIM_WIDE   = 12'h7FF;

    typedef struct packed {
        logic             ok;
        logic [2:0]       step;
        logic [CNT_W-1:0] count;
    } size_dec_t;

    typedef struct packed {
        logic follow;
        logic intr;
    } link_ctl_t;

    function automatic size_dec_t decode_size(input logic [31:0] w);
        size_dec_t        d;
        logic [CNT_W-1:0] lim;
        logic             valid;
        d.count = w[CNT_W-1:0];
        valid   = 1'b1;
        case (w[WCODE_LSB+1:WCODE_LSB])
            WC_BYTE: begin d.step = 3'd1; lim = LIM_NARROW; end
            WC_HALF: begin d.step = 3'd2; lim = LIM_NARROW; end
            WC_WORD: begin d.step = 3'd4; lim = LIM_WIDE;   end
            default: begin d.step = 3'd0; lim = '0; valid = 1'b0; end
        endcase
        d.ok = valid && (d.count <= lim);
        return d;
    endfunction

endpackage

// File: rtl/lde_regs.sv
module lde_regs
    import lde_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_we,
    input  logic [1:0]    host_idx,
    input  logic [DW-1:0] host_data,
    input  logic          load_we,
    input  logic [1:0]    load_idx,
    input  logic [DW-1:0] load_data,
    input  logic          beat_adv,
    input  logic [2:0]    step,
    output logic [DW-1:0] dev_q,
    output logic [DW-1:0] mem_q,
    output logic [DW-1:0] size_q,
    output logic [DW-1:0] link_q
);
    localparam int NWORDS = 4;

    logic [DW-1:0] word_q [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[g] <= '0;
            end else if (load_we && load_idx == 2'(g)) begin
                word_q[g] <= load_data;
            end else if (host_we && host_idx == 2'(g)) begin
                word_q[g] <= host_data;
            end else if (beat_adv && g == 1) begin
                word_q[g] <= word_q[g] + DW'(step);
            end else if (beat_adv && g == 2) begin
                word_q[g][CNT_W-1:0] <= word_q[g][CNT_W-1:0] - 1'b1;
            end
        end
    end

    assign dev_q  = word_q[0];
    assign mem_q  = word_q[1];
    assign size_q = word_q[2];
    assign link_q = word_q[3];
endmodule

// File: rtl/lde_ctrl.sv
module lde_ctrl
    import lde_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic          dir,
    input  logic          start,
    input  logic [DW-1:0] dev_addr,
    input  logic [DW-1:0] mem_addr,
    input  logic [DW-1:0] size_w,
    input  logic [DW-1:0] link_w,
    input  logic          bus_gnt,
    output lde_state_e    state,
    output logic          bus_req,
    output logic          bus_we,
    output logic [DW-1:0] bus_addr,
    output logic          load_we,
    output logic [1:0]    load_idx,
    output logic          capture,
    output logic          beat_adv,
    output logic [2:0]    step,
    output logic          evt_done,
    output logic          evt_err
);
    lde_state_e    st_q;
    logic [DW-1:0] ptr_q;
    logic [1:0]    idx_q;
    logic          wr_ph_q;
    logic          chain_q;
    logic          done_q;
    logic          err_q;

    size_dec_t     dec;
    link_ctl_t     link;
    logic          stop_req;
    logic          desc_end;
    logic [DW-1:0] link_ptr;

    always_comb begin
        dec      = decode_size(32'(size_w));
        link     = link_ctl_t'(link_w[1:0]);
        link_ptr = {link_w[DW-1:2], 2'b00};
        stop_req = (mode == MD_OFF);
        step     = dec.step;
        bus_req  = (st_q == ST_FETCH) || (st_q == ST_MOVE);
        bus_we   = (st_q == ST_MOVE) && wr_ph_q;
        if (st_q == ST_FETCH)
            bus_addr = ptr_q + DW'({idx_q, 2'b00});
        else if (wr_ph_q)
            bus_addr = dir ? dev_addr : mem_addr;
        else
            bus_addr = dir ? mem_addr : dev_addr;
        load_we  = (st_q == ST_FETCH) && bus_gnt;
        load_idx = idx_q;
        capture  = (st_q == ST_MOVE) && !wr_ph_q && bus_gnt;
        beat_adv = (st_q == ST_MOVE) && wr_ph_q && bus_gnt;
        desc_end = (!stop_req && st_q == ST_DECODE && dec.ok && dec.count == '0)
                || (!stop_req && beat_adv && dec.count == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            ptr_q   <= '0;
            idx_q   <= '0;
            wr_ph_q <= 1'b0;
            chain_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start && mode == MD_CHAIN) begin
                        ptr_q   <= link_ptr;
                        idx_q   <= '0;
                        chain_q <= 1'b1;
                        st_q    <= ST_FETCH;
                    end else if (start && mode == MD_SINGLE) begin
                        chain_q <= 1'b0;
                        st_q    <= ST_DECODE;
                    end
                end
                ST_FETCH: begin
                    if (bus_gnt) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == 2'd3) st_q <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (stop_req) begin
                        st_q <= ST_IDLE;
                    end else if (!dec.ok) begin
                        err_q <= 1'b1;
                        st_q  <= ST_IDLE;
                    end else if (dec.count != '0) begin
                        wr_ph_q <= 1'b0;
                        st_q    <= ST_MOVE;
                    end
                end
                default: begin
                    if (bus_gnt) begin
                        wr_ph_q <= !wr_ph_q;
                        if (wr_ph_q && stop_req) st_q <= ST_IDLE;
                    end
                end
            endcase
            if (desc_end) begin
                done_q <= link.intr;
                if (chain_q && link.follow) begin
                    ptr_q <= link_ptr;
                    idx_q <= '0;
                    st_q  <= ST_FETCH;
                end else begin
                    st_q <= ST_IDLE;
                end
            end
        end
    end

    assign state    = st_q;
    assign evt_done = done_q;
    assign evt_err  = err_q;
endmodule

// File: rtl/lde_channel.sv
module lde_channel
    import lde_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic          dir,
    input  logic          start,
    input  logic          reg_we,
    input  logic [1:0]    reg_idx,
    input  logic [DW-1:0] reg_wdata,
    output logic          bus_req,
    output logic          bus_we,
    output logic [DW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_gnt,
    input  logic [DW-1:0] bus_rdata,
    output logic [1:0]    chan_state,
    output logic          evt_done,
    output logic          evt_err
);
    lde_state_e    st;
    logic [DW-1:0] dev_q, mem_q, size_q, link_q;
    logic          load_we, capture, beat_adv;
    logic [1:0]    load_idx;
    logic [2:0]    step;
    logic [DW-1:0] beat_buf_q;

    lde_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .host_we   (reg_we && st == ST_IDLE),
        .host_idx  (reg_idx),
        .host_data (reg_wdata),
        .load_we   (load_we),
        .load_idx  (load_idx),
        .load_data (bus_rdata),
        .beat_adv  (beat_adv),
        .step      (step),
        .dev_q     (dev_q),
        .mem_q     (mem_q),
        .size_q    (size_q),
        .link_q    (link_q)
    );

    lde_ctrl #(.DW(DW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .dir      (dir),
        .start    (start),
        .dev_addr (dev_q),
        .mem_addr (mem_q),
        .size_w   (size_q),
        .link_w   (link_q),
        .bus_gnt  (bus_gnt),
        .state    (st),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .load_we  (load_we),
        .load_idx (load_idx),
        .capture  (capture),
        .beat_adv (beat_adv),
        .step     (step),
        .evt_done (evt_done),
        .evt_err  (evt_err)
    );

    always_ff @(posedge clk) begin
        if (rst)          beat_buf_q <= '0;
        else if (capture) beat_buf_q <= bus_rdata;
    end

    assign bus_wdata  = beat_buf_q;
    assign chan_state = st;
endmodule

// File: rtl/lde_channel_checker.sv
module lde_channel_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [1:0]    mode,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          bus_we,
    input logic [DW-1:0] bus_addr,
    input logic [1:0]    chan_state,
    input logic          evt_done,
    input logic          evt_err
);
    p_idle_no_bus_r8: assert property (@(posedge clk) disable iff (rst)
        chan_state == 2'd0 |-> !bus_req);

    p_hold_until_grant_r11: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    p_fetch_aligned_r13: assert property (@(posedge clk) disable iff (rst)
        chan_state == 2'd1 |-> bus_addr[1:0] == 2'b00);

    p_fetch_is_read_r5: assert property (@(posedge clk) disable iff (rst)
        chan_state == 2'd1 |-> !bus_we);

    p_err_alone_idle_r7: assert property (@(posedge clk) disable iff (rst)
        evt_err |-> chan_state == 2'd0 && !evt_done);

    p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        chan_state == 2'd3 && !bus_gnt && start |=> chan_state == 2'd3);

    p_off_stops_r10: assert property (@(posedge clk) disable iff (rst)
        chan_state == 2'd3 && bus_we && bus_gnt && mode == 2'd0 |=> chan_state == 2'd0 && !evt_done);
endmodule

bind lde_channel lde_channel_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mode       (mode),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .chan_state (chan_state),
    .evt_done   (evt_done),
    .evt_err    (evt_err)
);

// File: tb/lde_channel_bench.sv
`timescale 1ns/1ps
module lde_channel_bench;
    localparam int DW = 32;
    localparam logic [31:0] DEV = 32'h0000_03F0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'd0;
    logic          dir = 1'b0;
    logic          start = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_idx = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic          bus_req, bus_we;
    logic [DW-1:0] bus_addr, bus_wdata, bus_rdata;
    logic          bus_gnt = 1'b0;
    logic [1:0]    chan_state;
    logic          evt_done, evt_err;

    logic          pk_en = 1'b0;
    logic [7:0]    pk_a = '0;
    logic [31:0]   pk_d = '0;

    logic [31:0] mem  [256];
    logic [31:0] rd_a [256];
    logic [31:0] wr_a [256];
    logic [31:0] wr_d [256];
    int rd_n = 0, wr_n = 0, dev_rd_n = 0, done_n = 0, err_n = 0, hold_bad = 0;
    int seen_st [4] = '{0, 0, 0, 0};
    int gcyc = 0, cyc = 0;
    logic prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;
    int nchk = 0, nerr = 0;

    always #2 clk = ~clk;

    lde_channel #(.DW(DW)) u_lde_channel (
        .clk(clk), .rst(rst), .mode(mode), .dir(dir), .start(start),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
        .chan_state(chan_state), .evt_done(evt_done), .evt_err(evt_err)
    );

    assign bus_rdata = (bus_addr == DEV) ? 32'hD000_0000 + 32'(dev_rd_n)
                                         : mem[bus_addr[9:2]];

    always @(negedge clk) begin
        gcyc    <= gcyc + 1;
        bus_gnt <= (gcyc % 3) != 2;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'hA500_0000 + 32'(i);
        end else begin
            if (pk_en) mem[pk_a] <= pk_d;
            seen_st[chan_state] <= seen_st[chan_state] + 1;
            if (evt_done) done_n <= done_n + 1;
            if (evt_err)  err_n  <= err_n + 1;
            if (prev_wait && (!bus_req || bus_addr != prev_addr)) hold_bad <= hold_bad + 1;
            prev_wait <= bus_req && !bus_gnt;
            prev_addr <= bus_addr;
            if (bus_req && bus_gnt) begin
                if (bus_we) begin
                    if (bus_addr != DEV) mem[bus_addr[9:2]] <= bus_wdata;
                    if (wr_n < 256) begin
                        wr_a[wr_n] <= bus_addr;
                        wr_d[wr_n] <= bus_wdata;
                    end
                    wr_n <= wr_n + 1;
                end else begin
                    if (bus_addr == DEV) dev_rd_n <= dev_rd_n + 1;
                    if (rd_n < 256) rd_a[rd_n] <= bus_addr;
                    rd_n <= rd_n + 1;
                end
            end
        end
        if (cyc == 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", nchk + 1, nerr + 1);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] i, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_idx = i; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); pk_en = 1'b1; pk_a = a[9:2]; pk_d = d;
        @(negedge clk); pk_en = 1'b0;
    endtask

    task automatic go(input logic [1:0] m);
        @(negedge clk); mode = m; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk); @(negedge clk);
        while (chan_state != 2'd0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load4(input logic [31:0] d, input logic [31:0] m,
                         input logic [31:0] s, input logic [31:0] l);
        wreg(2'd0, d); wreg(2'd1, m); wreg(2'd2, s); wreg(2'd3, l);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 state after reset", 32'(chan_state), 32'd0);
        chk("R1 no request after reset", 32'(bus_req), 32'd0);
        chk("R1 no events after reset", 32'({evt_done, evt_err}), 32'd0);
    endtask

    task automatic t_single_m2d_word();
        int wb = wr_n, rb = rd_n, db = done_n, f0 = seen_st[1], d0 = seen_st[2], m0 = seen_st[3];
        dir = 1'b1;
        load4(DEV, 32'h100, 32'h0000_0004, 32'h1);
        go(2'd2);
        wait_idle();
        chk("R2 beat count", 32'(wr_n - wb), 32'd4);
        for (int i = 0; i < 4; i++) begin
            chk("R3 read side is memory", rd_a[rb+i], 32'h100 + 32'(4*i));
            chk("R3 write side is device", wr_a[wb+i], DEV);
            chk("R2 data moved", wr_d[wb+i], 32'hA500_0040 + 32'(i));
        end
        chk("R6 end with interrupt pulses once", 32'(done_n - db), 32'd1);
        chk("R8 no fetch state in single mode", 32'(seen_st[1] - f0), 32'd0);
        chk("R8 check state seen", 32'(seen_st[2] > d0), 32'd1);
        chk("R8 move state seen", 32'(seen_st[3] > m0), 32'd1);
    endtask

    task automatic t_single_d2m_half();
        int wb = wr_n, db = done_n, vb = dev_rd_n;
        dir = 1'b0;
        load4(DEV, 32'h200, 32'h0000_2004, 32'h2);
        go(2'd2);
        wait_idle();
        chk("R3 dev-to-mem beat count", 32'(wr_n - wb), 32'd4);
        for (int i = 0; i < 4; i++) begin
            chk("R4 2-byte memory stride", wr_a[wb+i], 32'h200 + 32'(2*i));
            chk("R3 device data to memory", wr_d[wb+i], 32'hD000_0000 + 32'(vb + i));
        end
        chk("R6 single mode ignores follow, no interrupt", 32'(done_n - db), 32'd0);
        chk("R6 single mode stops after one run", 32'(chan_state), 32'd0);
    endtask

    task automatic t_single_byte();
        int wb = wr_n, rb = rd_n;
        dir = 1'b1;
        load4(DEV, 32'h101, 32'h0000_3003, 32'h1);
        go(2'd2);
        wait_idle();
        chk("R4 1-byte beat count", 32'(wr_n - wb), 32'd3);
        for (int i = 0; i < 3; i++)
            chk("R4 1-byte memory stride", rd_a[rb+i], 32'h101 + 32'(i));
    endtask

    task automatic t_chain();
        int wb = wr_n, rb = rd_n, db = done_n, f0 = seen_st[1];
        logic [31:0] exp_rd [11];
        poke(32'h300, DEV); poke(32'h304, 32'h120); poke(32'h308, 32'h2); poke(32'h30C, 32'h313);
        poke(32'h310, DEV); poke(32'h314, 32'h140); poke(32'h318, 32'h1); poke(32'h31C, 32'h1);
        dir = 1'b1;
        load4(32'h0, 32'h0, 32'h0, 32'h302);
        go(2'd1);
        wait_idle();
        exp_rd = '{32'h300, 32'h304, 32'h308, 32'h30C, 32'h120, 32'h124,
                   32'h310, 32'h314, 32'h318, 32'h31C, 32'h140};
        for (int i = 0; i < 11; i++)
            chk("R5 R13 fetch and read order", rd_a[rb+i], exp_rd[i]);
        chk("R6 chain total beats", 32'(wr_n - wb), 32'd3);
        chk("R5 first descriptor data", wr_d[wb], 32'hA500_0048);
        chk("R5 second element", wr_d[wb+1], 32'hA500_0049);
        chk("R6 followed descriptor data", wr_d[wb+2], 32'hA500_0050);
        chk("R6 one pulse per interrupt descriptor", 32'(done_n - db), 32'd2);
        chk("R8 fetch state seen", 32'(seen_st[1] - f0 >= 8), 32'd1);
    endtask

    task automatic t_zero_count();
        int wb = wr_n, db = done_n;
        load4(DEV, 32'h100, 32'h0000_0000, 32'h1);
        go(2'd2);
        wait_idle();
        chk("R12 zero count moves nothing", 32'(wr_n - wb), 32'd0);
        chk("R12 zero count still completes", 32'(done_n - db), 32'd1);
    endtask

    task automatic t_bad_size(input logic [31:0] s, input string tag);
        int wb = wr_n, rb = rd_n, db = done_n, eb = err_n;
        load4(DEV, 32'h100, s, 32'h1);
        go(2'd2);
        wait_idle();
        chk({"R7 error pulse ", tag}, 32'(err_n - eb), 32'd1);
        chk({"R7 no beat ", tag}, 32'((wr_n - wb) + (rd_n - rb)), 32'd0);
        chk({"R7 no completion ", tag}, 32'(done_n - db), 32'd0);
        chk({"R7 back to idle ", tag}, 32'(chan_state), 32'd0);
    endtask

    task automatic t_busy_ignored();
        int wb = wr_n, db = done_n;
        dir = 1'b1;
        load4(DEV, 32'h100, 32'h0000_0006, 32'h1);
        go(2'd2);
        repeat (5) @(negedge clk);
        wreg(2'd1, 32'h000);
        wreg(2'd2, 32'h0000_0002);
        go(2'd2);
        wait_idle();
        chk("R9 busy writes and start ignored, beats", 32'(wr_n - wb), 32'd6);
        for (int i = 0; i < 6; i++)
            chk("R9 data unaffected", wr_d[wb+i], 32'hA500_0040 + 32'(i));
        chk("R9 single completion", 32'(done_n - db), 32'd1);
    endtask

    task automatic t_stop();
        int wb = wr_n, rb = rd_n, db = done_n;
        dir = 1'b1;
        load4(DEV, 32'h100, 32'h0000_0028, 32'h1);
        go(2'd2);
        repeat (20) @(negedge clk);
        mode = 2'd0;
        wait_idle();
        chk("R10 stopped early", 32'((wr_n - wb) > 0 && (wr_n - wb) < 40), 32'd1);
        chk("R10 stopped on beat boundary", 32'(rd_n - rb), 32'(wr_n - wb));
        chk("R10 no completion on stop", 32'(done_n - db), 32'd0);
        chk("R10 idle after stop", 32'(chan_state), 32'd0);
    endtask

    task automatic t_limits();
        int wb = wr_n, eb = err_n;
        dir = 1'b1;
        load4(DEV, 32'h100, 32'h0000_23FF, 32'h0);
        go(2'd2);
        wait_idle();
        chk("R7 2-byte limit accepted", 32'(wr_n - wb), 32'h3FF);
        wb = wr_n;
        dir = 1'b0;
        load4(DEV, 32'h000, 32'h0000_07FF, 32'h0);
        go(2'd2);
        wait_idle();
        chk("R7 4-byte limit accepted", 32'(wr_n - wb), 32'h7FF);
        chk("R7 no error at limits", 32'(err_n - eb), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single_m2d_word();
        t_single_d2m_half();
        t_single_byte();
        t_chain();
        t_zero_count();
        t_bad_size(32'h0000_0800, "word over limit");
        t_bad_size(32'h0000_3400, "byte over limit");
        t_bad_size(32'h0000_1001, "reserved width");
        t_busy_ignored();
        t_stop();
        t_limits();
        chk("R11 request held until grant", 32'(hold_bad), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule